// File: doc/BRIEF.md
# Parallel NOR Flash Operation Sequencer

This block runs on the host side of a parallel NOR flash bus and turns one request into a finished program or erase. A request carries an operation code, a target byte address and a data byte. The block issues the unlock and command write cycles the flash needs. It then reads the device repeatedly until the device reports that the operation is complete, and returns a one-bit status.

Completion is detected from status bits that the device shows while it is busy. In toggle mode, the block compares bit 6 of two reads in a row. In complement mode, it checks bit 7 against the value it expects to see when the operation is finished. The mode is chosen per request by a plain control pin, which is sampled when the request is accepted. If the device never reports completion, a poll budget ends the operation with an error.

Requests use a valid/ready handshake, and the block takes one request at a time. `req_ready` is high only while the sequencer is idle. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. No further request is taken until the response has been consumed. The response is also valid/ready: `rsp_valid` stays high, with `rsp_err` stable, until `rsp_ready` is seen high. The data pins are split into out, enable and in, so that a pad-level tri-state buffer can be placed outside the block.

Top module: `flash_op_sequencer`

## Requirements
- R1: `req_ready` is high only when the block is idle. After a request is accepted, `req_ready` stays low until the response handshake has completed.
- R2: Whenever `flash_we_n` is low, `flash_ce_n` is low and `flash_oe_n` is high.
- R3: Each write strobe holds `flash_we_n` low for exactly WE_LOW_CYC clock cycles. Address and data stay stable while the strobe is low.
- R4: Operation code 0 (program) produces exactly four writes, in this order: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (target address, data byte).
- R5: Erase operation codes produce exactly six writes. The first five are (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55). The sixth write depends on the code:
  - code 1 (sector erase): 0x30 to the target address with its low 12 bits cleared;
  - code 2 (block erase): 0x50 to the target address with its low 16 bits cleared;
  - code 3 (chip erase): 0x10 to 0x5555.
- R6: In toggle mode (`poll_dq7` = 0), the operation completes on the first read whose bit 6 equals bit 6 of the read before it, within the same operation.
- R7: In complement mode after a program, the operation completes on the first read whose bit 7 equals bit 7 of the programmed data byte.
- R8: In complement mode after any erase, the operation completes on the first read whose bit 7 is 1.
- R9: If completion is not seen within MAX_POLLS reads, the operation ends after exactly MAX_POLLS reads with `rsp_err` = 1. A completed operation returns `rsp_err` = 0.
- R10: `flash_dq_oe` is high only while `flash_we_n` is low and for one cycle after it. It is never high while `flash_oe_n` is low.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_err` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| poll_dq7 | input | 1 | 1 complement-bit polling, 0 toggle polling |
| rsp_valid | output | 1 | Operation finished |
| rsp_ready | input | 1 | Response consumed |
| rsp_err | output | 1 | Poll budget ran out |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_addr | output | AW | Flash address |
| flash_dq_o | output | 8 | Data toward flash |
| flash_dq_oe | output | 1 | Drive enable for flash_dq_o |
| flash_dq_i | input | 8 | Data from flash |

## Verification
A write cycle takes 3 + WE_LOW_CYC clocks: one setup clock, the strobe, one hold clock and one idle clock. A read takes 2 + RD_WAIT_CYC clocks, and the data is captured in its last strobe clock. The response appears in the clock after the idle clock of the deciding read. The bench samples every output on the falling edge. Its monitor matches each rising `flash_we_n` against the head of an expected-write queue, and measures the width of each strobe as it happens. The response is awaited in a bounded loop. The number of reads then counted is compared with a count the bench derives from its own flash model and the polling rule.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  localparam logic [15:0] UNLK_ADR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADR_B = 16'h2AAA;
  localparam logic [7:0]  UNLK_KEY_A = 8'hAA;
  localparam logic [7:0]  UNLK_KEY_B = 8'h55;
  localparam logic [7:0]  CMD_WRITE  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_BLK    = 8'h50;
endpackage

// File: rtl/nfs_cmd_gen.sv
// Address/data of write step N of the selected command sequence.
module nfs_cmd_gen
  import nfs_pkg::*;
#(
  parameter int AW         = 17,
  parameter int SECT_BYTES = 4096,
  parameter int BLK_BYTES  = 65536
) (
  input  op_e           op,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  input  logic [2:0]    step,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [2:0]    last_step
);
  localparam int SECT_LG = $clog2(SECT_BYTES);
  localparam int BLK_LG  = $clog2(BLK_BYTES);
  localparam logic [AW-1:0] SECT_MASK = {AW{1'b1}} << SECT_LG;
  localparam logic [AW-1:0] BLK_MASK  = {AW{1'b1}} << BLK_LG;
  localparam logic [AW-1:0] ADR_A = AW'(UNLK_ADR_A);
  localparam logic [AW-1:0] ADR_B = AW'(UNLK_ADR_B);

  logic is_prog;
  assign is_prog   = (op == OP_PROG);
  assign last_step = is_prog ? 3'd3 : 3'd5;

  always_comb begin
    wr_addr = ADR_A;
    wr_data = UNLK_KEY_A;
    unique case (step)
      3'd0: begin wr_addr = ADR_A; wr_data = UNLK_KEY_A; end
      3'd1: begin wr_addr = ADR_B; wr_data = UNLK_KEY_B; end
      3'd2: begin wr_addr = ADR_A; wr_data = is_prog ? CMD_WRITE : CMD_ERASE; end
      3'd3: begin
        if (is_prog) begin
          wr_addr = tgt_addr;
          wr_data = tgt_data;
        end else begin
          wr_addr = ADR_A;
          wr_data = UNLK_KEY_A;
        end
      end
      3'd4: begin wr_addr = ADR_B; wr_data = UNLK_KEY_B; end
      default: begin
        unique case (op)
          OP_SECT: begin wr_addr = tgt_addr & SECT_MASK; wr_data = CMD_SECT; end
          OP_BLK:  begin wr_addr = tgt_addr & BLK_MASK;  wr_data = CMD_BLK;  end
          default: begin wr_addr = ADR_A;                wr_data = CMD_CHIP; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/nfs_bus_cycle.sv
// One flash bus cycle: setup, strobe, (hold for writes), idle gap.
module nfs_bus_cycle #(
  parameter int AW          = 17,
  parameter int WE_LOW_CYC  = 3,
  parameter int RD_WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    dq_o,
  output logic          dq_oe,
  input  logic [7:0]    dq_i
);
  localparam int MAXC = (WE_LOW_CYC > RD_WAIT_CYC) ? WE_LOW_CYC : RD_WAIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_GAP} ph_e;
  ph_e           ph_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_o <= '0;
      dq_o   <= '0;
      rdata  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) begin
          wr_q   <= is_wr;
          addr_o <= addr;
          dq_o   <= wdata;
          ph_q   <= PH_SETUP;
        end
        PH_SETUP: begin
          cnt_q <= '0;
          ph_q  <= PH_STROBE;
        end
        PH_STROBE: begin
          if (wr_q) begin
            if (cnt_q == CW'(WE_LOW_CYC - 1)) ph_q <= PH_HOLD;
            else cnt_q <= cnt_q + 1'b1;
          end else begin
            if (cnt_q == CW'(RD_WAIT_CYC - 1)) begin
              rdata <= dq_i;
              ph_q  <= PH_GAP;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HOLD: ph_q <= PH_GAP;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy  = (ph_q != PH_IDLE);
  assign done  = (ph_q == PH_GAP);
  assign ce_n  = (ph_q == PH_IDLE) || (ph_q == PH_GAP);
  assign we_n  = !(wr_q && ph_q == PH_STROBE);
  assign oe_n  = !(!wr_q && (ph_q == PH_SETUP || ph_q == PH_STROBE));
  assign dq_oe = wr_q && (ph_q == PH_STROBE || ph_q == PH_HOLD);

  // checker state: length of the current write strobe
  logic [7:0] we_lo_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_lo_q <= '0;
    else if (!we_n) we_lo_q <= we_lo_q + 1'b1;
    else we_lo_q <= '0;
  end

  p_we_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));
  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo_q == 8'(WE_LOW_CYC)));
  p_we_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(addr_o) && $stable(dq_o)));
  p_dq_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n || $past(!we_n)));
  p_dq_no_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
endmodule

// File: rtl/nfs_poll_eval.sv
// Decides completion from one status read, remembering the previous bit 6.
module nfs_poll_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       mode_dq7,
  input  logic       is_prog,
  input  logic       exp_b7,
  input  logic       smp_valid,
  input  logic [7:0] smp,
  output logic       complete
);
  logic have_prev_q;
  logic prev_b6_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_b6_q   <= 1'b0;
    end else if (clear) begin
      have_prev_q <= 1'b0;
    end else if (smp_valid) begin
      have_prev_q <= 1'b1;
      prev_b6_q   <= smp[6];
    end
  end

  always_comb begin
    if (mode_dq7) complete = (smp[7] == (is_prog ? exp_b7 : 1'b1));
    else          complete = have_prev_q && (smp[6] == prev_b6_q);
  end

  p_toggle_needs_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mode_dq7 && !have_prev_q) |-> !complete);
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import nfs_pkg::*;
#(
  parameter int AW          = 17,
  parameter int WE_LOW_CYC  = 3,
  parameter int RD_WAIT_CYC = 2,
  parameter int MAX_POLLS   = 1024,
  parameter int SECT_BYTES  = 4096,
  parameter int BLK_BYTES   = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          poll_dq7,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_err,
  output logic          flash_ce_n,
  output logic          flash_oe_n,
  output logic          flash_we_n,
  output logic [AW-1:0] flash_addr,
  output logic [7:0]    flash_dq_o,
  output logic          flash_dq_oe,
  input  logic [7:0]    flash_dq_i
);
  localparam int PCW = $clog2(MAX_POLLS + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_POLL, S_RESP} st_e;
  st_e            st_q;
  op_e            op_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;
  logic           dq7_q;
  logic [2:0]     step_q;
  logic [PCW-1:0] polls_q;
  logic           err_q;

  logic          accept;
  logic [AW-1:0] cg_addr;
  logic [7:0]    cg_data;
  logic [2:0]    cg_last;
  logic          bus_start, bus_wr, bus_busy, bus_done;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_rdata;
  logic          rd_done, complete;

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (st_q == S_RESP);
  assign rsp_err   = err_q;

  nfs_cmd_gen #(.AW(AW), .SECT_BYTES(SECT_BYTES), .BLK_BYTES(BLK_BYTES)) u_cmd (
    .op(op_q), .tgt_addr(addr_q), .tgt_data(data_q), .step(step_q),
    .wr_addr(cg_addr), .wr_data(cg_data), .last_step(cg_last)
  );

  assign bus_wr    = (st_q == S_SEQ);
  assign bus_addr  = bus_wr ? cg_addr : addr_q;
  assign bus_start = ((st_q == S_SEQ) || (st_q == S_POLL)) && !bus_busy;

  nfs_bus_cycle #(.AW(AW), .WE_LOW_CYC(WE_LOW_CYC), .RD_WAIT_CYC(RD_WAIT_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_wr(bus_wr),
    .addr(bus_addr), .wdata(cg_data), .busy(bus_busy), .done(bus_done),
    .rdata(bus_rdata), .ce_n(flash_ce_n), .oe_n(flash_oe_n), .we_n(flash_we_n),
    .addr_o(flash_addr), .dq_o(flash_dq_o), .dq_oe(flash_dq_oe), .dq_i(flash_dq_i)
  );

  assign rd_done = (st_q == S_POLL) && bus_done;

  nfs_poll_eval u_eval (
    .clk(clk), .rst_n(rst_n), .clear(accept), .mode_dq7(dq7_q),
    .is_prog(op_q == OP_PROG), .exp_b7(data_q[7]),
    .smp_valid(rd_done), .smp(bus_rdata), .complete(complete)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      dq7_q   <= 1'b0;
      step_q  <= '0;
      polls_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          op_q    <= op_e'(req_op);
          addr_q  <= req_addr;
          data_q  <= req_data;
          dq7_q   <= poll_dq7;
          step_q  <= '0;
          polls_q <= '0;
          err_q   <= 1'b0;
          st_q    <= S_SEQ;
        end
        S_SEQ: if (bus_done) begin
          if (step_q == cg_last) st_q <= S_POLL;
          else step_q <= step_q + 1'b1;
        end
        S_POLL: if (bus_done) begin
          if (complete) begin
            st_q <= S_RESP;
          end else if (polls_q == PCW'(MAX_POLLS - 1)) begin
            err_q <= 1'b1;
            st_q  <= S_RESP;
          end else begin
            polls_q <= polls_q + 1'b1;
          end
        end
        default: if (rsp_ready) st_q <= S_IDLE;
      endcase
    end
  end

  // checker state: falling write strobes since acceptance
  logic       we_prev_q;
  logic [3:0] wr_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      wr_seen_q <= '0;
    end else begin
      we_prev_q <= flash_we_n;
      if (accept) wr_seen_q <= '0;
      else if (we_prev_q && !flash_we_n) wr_seen_q <= wr_seen_q + 1'b1;
    end
  end

  p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_seq_len_r4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POLL && polls_q == '0 && $fell(flash_oe_n)) |->
      (wr_seen_q == ((op_q == OP_PROG) ? 4'd4 : 4'd6)));
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err)));
  p_no_write_in_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POLL) |-> flash_we_n);
endmodule

// File: tb/flash_op_sequencer_test.sv
`timescale 1ns/1ps
module flash_op_sequencer_test;
  localparam int AW  = 17;
  localparam int WEC = 3;
  localparam int MXP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic poll_dq7 = 1'b0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_err;
  logic ce_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] f_addr;
  logic [7:0] dq_o, dq_i;

  flash_op_sequencer #(.AW(AW), .WE_LOW_CYC(WEC), .RD_WAIT_CYC(2), .MAX_POLLS(MXP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .poll_dq7(poll_dq7),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .flash_ce_n(ce_n), .flash_oe_n(oe_n), .flash_we_n(we_n), .flash_addr(f_addr),
    .flash_dq_o(dq_o), .flash_dq_oe(dq_oe), .flash_dq_i(dq_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model: status while busy, final value after
  logic [31:0] rd_cnt = 0, rd_base = 0, busy_cfg = 0, rd_idx;
  logic [7:0] fin_val = 8'hFF;
  logic st_b7 = 1'b0;
  assign rd_idx = rd_cnt - rd_base;
  assign dq_i = (rd_idx < busy_cfg) ? {st_b7, rd_idx[0], 6'b0} : fin_val;

  // scoreboard of expected writes
  logic [AW-1:0] exp_a[$];
  logic [7:0]    exp_d[$];
  int viol_r2 = 0, viol_r3 = 0, viol_r10 = 0;
  int lo_len = 0;
  logic pwe = 1'b1, poe = 1'b1, pdq = 1'b0;
  logic [AW-1:0] cap_a;
  logic [7:0] cap_d;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) begin
        lo_len++;
        if (!(!ce_n && oe_n)) viol_r2++;
        if (!pwe && (f_addr != cap_a || dq_o != cap_d)) viol_r3++;
        cap_a = f_addr;
        cap_d = dq_o;
      end
      if (dq_oe && !(!we_n || !pwe)) viol_r10++;
      if (!oe_n && dq_oe) viol_r10++;
      if (!pwe && we_n) begin
        if (lo_len != WEC) viol_r3++;
        lo_len = 0;
        if (exp_a.size() == 0) chk(0, "R4/R5", "unexpected write", int'(cap_a), 0);
        else begin
          logic [AW-1:0] ea;
          logic [7:0] ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(cap_a == ea && cap_d == ed, "R4/R5", "write addr/data",
              int'({cap_a, cap_d}), int'({ea, ed}));
        end
      end
      if (!poe && oe_n) rd_cnt++;
      pwe = we_n;
      poe = oe_n;
      pdq = dq_oe;
    end
  end

  function automatic void calc(input bit prog, input bit m7, input logic [7:0] d,
                               input int busy, output int nrd, output bit err);
    logic prev6 = 1'b0;
    nrd = MXP;
    err = 1'b1;
    for (int i = 0; i < MXP; i++) begin
      logic [7:0] v;
      logic [31:0] ii;
      bit fin;
      ii = i;
      v = (i < busy) ? {(prog ? ~d[7] : 1'b0), ii[0], 6'b0} : (prog ? d : 8'hFF);
      fin = m7 ? (v[7] == (prog ? d[7] : 1'b1)) : (i > 0 && v[6] == prev6);
      if (fin) begin
        nrd = i + 1;
        err = 1'b0;
        return;
      end
      prev6 = v[6];
    end
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [7:0] d, input bit m7, input int busy,
                        input bit slow_rsp, input string rq);
    int enrd, v2, v3, v10, w;
    bit eerr, hold_err, prog;
    prog = (op == 2'd0);
    calc(prog, m7, d, busy, enrd, eerr);
    exp_a.push_back(17'h05555); exp_d.push_back(8'hAA);
    exp_a.push_back(17'h02AAA); exp_d.push_back(8'h55);
    if (prog) begin
      exp_a.push_back(17'h05555); exp_d.push_back(8'hA0);
      exp_a.push_back(a);         exp_d.push_back(d);
    end else begin
      exp_a.push_back(17'h05555); exp_d.push_back(8'h80);
      exp_a.push_back(17'h05555); exp_d.push_back(8'hAA);
      exp_a.push_back(17'h02AAA); exp_d.push_back(8'h55);
      case (op)
        2'd1: begin exp_a.push_back(a & 17'h1F000); exp_d.push_back(8'h30); end
        2'd2: begin exp_a.push_back(a & 17'h10000); exp_d.push_back(8'h50); end
        default: begin exp_a.push_back(17'h05555); exp_d.push_back(8'h10); end
      endcase
    end
    @(negedge clk);
    busy_cfg = busy;
    st_b7 = prog ? ~d[7] : 1'b0;
    fin_val = prog ? d : 8'hFF;
    rd_base = rd_cnt;
    v2 = viol_r2; v3 = viol_r3; v10 = viol_r10;
    rsp_ready = !slow_rsp;
    req_op = op; req_addr = a; req_data = d; poll_dq7 = m7; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1", "ready while idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready after accept", int'(req_ready), 0);
    w = 0;
    while (!rsp_valid && w < 5000) begin
      @(negedge clk);
      w++;
      if (!rsp_valid && req_ready) chk(0, "R1", "ready while busy", 1, 0);
    end
    chk(rsp_valid == 1'b1, rq, "response seen", int'(rsp_valid), 1);
    chk(rsp_err == eerr, eerr ? "R9" : rq, "rsp_err", int'(rsp_err), int'(eerr));
    chk(int'(rd_idx) == enrd, eerr ? "R9" : rq, "read count", int'(rd_idx), enrd);
    chk(exp_a.size() == 0, "R4/R5", "writes left over", exp_a.size(), 0);
    exp_a.delete(); exp_d.delete();
    chk(viol_r2 == v2, "R2", "strobe qualification", viol_r2 - v2, 0);
    chk(viol_r3 == v3, "R3", "strobe width/stability", viol_r3 - v3, 0);
    chk(viol_r10 == v10, "R10", "data drive window", viol_r10 - v10, 0);
    if (slow_rsp) begin
      hold_err = rsp_err;
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_err == hold_err, "R11", "response held",
          int'({rsp_valid, rsp_err}), int'({1'b1, hold_err}));
      chk(req_ready == 1'b0, "R1", "ready before rsp taken", int'(req_ready), 0);
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11", "response released", int'(rsp_valid), 0);
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe, "R2", "bus idle in reset",
        int'({ce_n, we_n, oe_n, dq_oe}), 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "reset handshake state",
        int'({req_ready, rsp_valid}), 2'b10);
    run_op(2'd0, 17'h01234, 8'h3C, 1'b0, 3, 1'b0, "R6");   // program, toggle
    run_op(2'd0, 17'h1ABCD, 8'h80, 1'b1, 2, 1'b0, "R7");   // program, complement, b7=1
    run_op(2'd0, 17'h00007, 8'h00, 1'b1, 4, 1'b1, "R7");   // program, complement, b7=0, slow rsp
    run_op(2'd1, 17'h12ABC, 8'h00, 1'b1, 3, 1'b0, "R8");   // sector erase
    run_op(2'd2, 17'h1F00F, 8'h00, 1'b0, 5, 1'b0, "R6");   // block erase, toggle
    run_op(2'd3, 17'h00000, 8'h00, 1'b1, 0, 1'b0, "R8");   // chip erase, done at once
    run_op(2'd3, 17'h00000, 8'h00, 1'b0, 2, 1'b0, "R6");   // chip erase, toggle
    run_op(2'd0, 17'h00100, 8'h5A, 1'b0, 100, 1'b1, "R9"); // timeout, toggle
    run_op(2'd1, 17'h03FFF, 8'h00, 1'b1, 100, 1'b0, "R9"); // timeout, complement
    run_op(2'd0, 17'h00200, 8'hC3, 1'b1, 1, 1'b0, "R7");   // recovers after timeout
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule